// File: doc/BRIEF.md
# Two-Stage Key-Guarded Watchdog Timer

This block is a watchdog peripheral on a simple 32-bit request/access register bus. Once enabled, a single counter measures a warning window and then a grace window. Both window lengths are powers of two picked from fixed tables. When the warning window runs out, a sticky status flag sets and an interrupt line rises. If software does not restart the timer before the grace window also runs out, the block emits a one-cycle system reset request, provided reset generation is armed.

Writes to the control and restart registers are accepted only straight after an unlock key has been written. A restart also needs a second magic value. The counter can advance on every bus clock or only on cycles where an external tick-enable input is high. A build parameter sets the warning-select field to 3 bits or 4 bits. Software can find out which width was built by writing all ones to the field and reading it back.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the control and status registers read 0, and `irq_o` and `rst_req_o` are low.
- R2: Control register (offset 0x10) layout: grace select in bits [10:8], warning select in bits [7:4], reset arm in bit 3, tick source in bit 1 (1 = every bus clock, 0 = `tick_in`), run in bit 0. Every other bit reads 0.
- R3: Writing 0x0000_5AA5 to offset 0x18 arms exactly the next bus write, whatever its address. Any write consumes the arm. A write to control or restart (0x14) that is not armed is ignored.
- R4: An armed write of 0x0000_CAFE to the restart register returns the counter to the start of the warning window. An armed write of any other value to that register has no effect.
- R5: The warning window is 2^N ticks. Select codes 0..15 give N = 6, 8, 10, 11, 12, 13, 14, 15, 17, 19, 21, 23, 25, 27, 29, 31. In bus-clock mode, `irq_o` rises 2^N+1 cycles after the access edge of the write that enables or restarts the timer.
- R6: The grace window is 2^(7+code) ticks and follows the warning window. `rst_req_o` is high for exactly one cycle, 2^Nw+2^Ng cycles after the enabling access edge.
- R7: Status bit 1 (offset 0x1C) is set when the warning window expires. It stays set until a 1 is written to that bit, and this write needs no key. `irq_o` is a level that follows the flag.
- R8: `rst_req_o` is produced only while both run and reset arm are set.
- R9: With tick source 0, the counter moves only on cycles where `tick_in` is high.
- R10: Clearing run stops the counter and clears it. A later enable starts a full warning window.
- R11: With the parameter `WIDE_WARN`=1, writing all ones to the warning field reads back 15. With 0 it reads back 7, because the top bit is not implemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | External count enable, used when tick source is 0 |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq_o | output | 1 | Warning-expired interrupt level |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
Every timing result is counted from the access edge of the write that caused it. Control and restart take effect on that edge. The counter's first step comes one edge later. The status flag, and so `irq_o`, lands one edge after the terminal count, which puts the interrupt at 2^Nw+1. The reset request comes out of the same register as the terminal count, which puts it at 2^Nw+2^Ng. The bench counts falling edges from the moment its write task returns and records the exact edge on which each output first goes high. Read data is sampled on the falling edge in the access phase, one register after the setup phase.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [31:0] ARM_KEY  = 32'h0000_5AA5;
  localparam logic [31:0] KICK_KEY = 32'h0000_CAFE;

  localparam logic [7:0] OFS_CTRL = 8'h10;
  localparam logic [7:0] OFS_KICK = 8'h14;
  localparam logic [7:0] OFS_ARM  = 8'h18;
  localparam logic [7:0] OFS_STAT = 8'h1C;

  typedef enum logic {ST_WARN, ST_GRACE} stage_e;

  typedef struct packed {
    logic [2:0] grace_sel;
    logic [3:0] warn_sel;
    logic       arm_rst;
    logic       bus_clk;
    logic       run;
  } ctrl_t;

  // exponent of the warning window for a select code
  function automatic logic [4:0] warn_exp(input logic [3:0] code);
    case (code)
      4'd0:  return 5'd6;
      4'd1:  return 5'd8;
      4'd2:  return 5'd10;
      4'd3:  return 5'd11;
      4'd4:  return 5'd12;
      4'd5:  return 5'd13;
      4'd6:  return 5'd14;
      4'd7:  return 5'd15;
      default: return 5'(5'd17 + 5'({code - 4'd8, 1'b0}));
    endcase
  endfunction

  function automatic logic [4:0] grace_exp(input logic [2:0] code);
    return 5'(code) + 5'd7;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter bit WIDE_WARN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic              expire_i,
  output ctrl_t             ctrl_o,
  output logic              kick_o,
  output logic              irq_o,
  output logic [31:0]       prdata
);

  logic  acc_wr, setup_rd, armed;
  logic  hit_ctrl, hit_kick, hit_arm, hit_stat;
  ctrl_t ctrl_q;
  logic  flag_q;

  assign acc_wr   = psel && penable && pwrite;
  assign setup_rd = psel && !penable && !pwrite;
  assign hit_ctrl = (paddr == OFS_CTRL[ADDR_W-1:0]);
  assign hit_kick = (paddr == OFS_KICK[ADDR_W-1:0]);
  assign hit_arm  = (paddr == OFS_ARM[ADDR_W-1:0]);
  assign hit_stat = (paddr == OFS_STAT[ADDR_W-1:0]);

  // restart is seen by the counter on the access edge itself
  assign kick_o = acc_wr && armed && hit_kick && (pwdata == KICK_KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
      prdata <= '0;
    end else begin
      if (acc_wr) armed <= hit_arm && (pwdata == ARM_KEY);
      if (acc_wr && armed && hit_ctrl) begin
        ctrl_q.grace_sel <= pwdata[10:8];
        ctrl_q.warn_sel  <= WIDE_WARN ? pwdata[7:4] : {1'b0, pwdata[6:4]};
        ctrl_q.arm_rst   <= pwdata[3];
        ctrl_q.bus_clk   <= pwdata[1];
        ctrl_q.run       <= pwdata[0];
      end
      if (expire_i) flag_q <= 1'b1;
      else if (acc_wr && hit_stat && pwdata[1]) flag_q <= 1'b0;
      if (setup_rd) begin
        if (hit_ctrl)
          prdata <= {21'd0, ctrl_q.grace_sel, ctrl_q.warn_sel, ctrl_q.arm_rst,
                     1'b0, ctrl_q.bus_clk, ctrl_q.run};
        else if (hit_stat) prdata <= {30'd0, flag_q, 1'b0};
        else prdata <= '0;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = flag_q;

  a_r3_locked_ctrl: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !armed && hit_ctrl) |=> (ctrl_q == $past(ctrl_q)));
  a_r7_flag_follows: assert property (@(posedge clk) disable iff (rst)
    expire_i |=> irq_o);
  a_r11_narrow_top: assert property (@(posedge clk) disable iff (rst)
    !WIDE_WARN |-> !ctrl_q.warn_sel[3]);

endmodule

// File: rtl/wdog_count.sv
module wdog_count
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t ctrl_i,
  input  logic  tick_i,
  input  logic  kick_i,
  output logic  expire_o,
  output logic  rst_req_o
);

  stage_e           stage;
  logic [CNT_W-1:0] cnt, warn_last, grace_last;
  logic             step, at_end;
  logic [63:0]      one;

  assign one        = 64'd1;
  assign warn_last  = CNT_W'((one << warn_exp(ctrl_i.warn_sel)) - 64'd1);
  assign grace_last = CNT_W'((one << grace_exp(ctrl_i.grace_sel)) - 64'd1);
  assign step       = ctrl_i.bus_clk ? 1'b1 : tick_i;
  assign at_end     = (stage == ST_WARN) ? (cnt == warn_last) : (cnt == grace_last);

  always_ff @(posedge clk) begin
    expire_o  <= 1'b0;
    rst_req_o <= 1'b0;
    if (rst || !ctrl_i.run || kick_i) begin
      cnt   <= '0;
      stage <= ST_WARN;
    end else if (step) begin
      if (at_end) begin
        cnt <= '0;
        if (stage == ST_WARN) begin
          stage    <= ST_GRACE;
          expire_o <= 1'b1;
        end else begin
          stage     <= ST_WARN;
          rst_req_o <= ctrl_i.arm_rst;
        end
      end else begin
        cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
      end
    end
  end

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  a_r8_reset_gated: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> $past(ctrl_i.run && ctrl_i.arm_rst));
  a_r10_idle_clear: assert property (@(posedge clk) disable iff (rst)
    !ctrl_i.run |=> (cnt == '0) && (stage == ST_WARN));
  a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.run && !ctrl_i.bus_clk && !tick_i && !kick_i) |=> $stable(cnt));

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter bit WIDE_WARN = 1'b1,
  parameter int CNT_W     = 32   // must hold 2^31 for the longest window
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              irq_o,
  output logic              rst_req_o
);

  ctrl_t ctrl;
  logic  kick, expire;

  wdog_regs #(.ADDR_W(ADDR_W), .WIDE_WARN(WIDE_WARN)) u_regs (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .expire_i(expire), .ctrl_o(ctrl),
    .kick_o(kick), .irq_o(irq_o), .prdata(prdata)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .tick_i(tick_in), .kick_i(kick),
    .expire_o(expire), .rst_req_o(rst_req_o)
  );

endmodule

// File: tb/wdog_two_stage_tb.sv
`timescale 1ns/1ps
module wdog_two_stage_tb;

  logic        clk = 1'b0, rst = 1'b1, tick_in = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, sel_n = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, prdata_n;
  logic        irq, rst_req, irq_n, rst_req_n;
  int          checks = 0, fails = 0, cyc = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_two_stage #(.ADDR_W(5), .WIDE_WARN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .tick_in(tick_in), .psel(psel && !sel_n),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq_o(irq), .rst_req_o(rst_req));

  wdog_two_stage #(.ADDR_W(5), .WIDE_WARN(1'b0)) u_dut_n (
    .clk(clk), .rst(rst), .tick_in(tick_in), .psel(psel && sel_n),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata_n), .irq_o(irq_n), .rst_req_o(rst_req_n));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = sel_n ? prdata_n : prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    bus_wr(5'h18, 32'h5AA5);
    bus_wr(5'h10, v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // edges counted from the last access edge; -1 means never seen
  task automatic time_events(input int max, output int t_irq, output int t_rst, output int n_rst);
    t_irq = -1; t_rst = -1; n_rst = 0;
    for (int k = 1; k <= max; k++) begin
      @(negedge clk);
      if (irq && t_irq < 0) t_irq = k;
      if (rst_req) begin n_rst++; if (t_rst < 0) t_rst = k; end
    end
  endtask

  task automatic cleanup();
    set_ctrl(32'h0);
    bus_wr(5'h1C, 32'h2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(5'h10, d); chk(d == 0, "R1 ctrl after reset", d, 0);
    bus_rd(5'h1C, d); chk(d == 0, "R1 status after reset", d, 0);
    chk(!irq && !rst_req, "R1 outputs low", {irq, rst_req}, 0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    set_ctrl(32'h0000_05AF);
    bus_rd(5'h10, d); chk(d == 32'h5AB, "R2 field readback", d, 32'h5AB);
    set_ctrl(32'h0000_00F0);
    bus_rd(5'h10, d); chk(d == 32'hF0, "R11 wide warn field", d, 32'hF0);
    sel_n = 1'b1;
    set_ctrl(32'h0000_00F0);
    bus_rd(5'h10, d); chk(d == 32'h70, "R11 narrow warn field", d, 32'h70);
    sel_n = 1'b0;
    set_ctrl(32'h0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    bus_wr(5'h10, 32'h3);
    bus_rd(5'h10, d); chk(d == 0, "R3 ctrl write without key", d, 0);
    set_ctrl(32'h10);
    bus_wr(5'h10, 32'h20);
    bus_rd(5'h10, d); chk(d == 32'h10, "R3 key consumed", d, 32'h10);
    bus_wr(5'h18, 32'h1234);
    bus_wr(5'h10, 32'h30);
    bus_rd(5'h10, d); chk(d == 32'h10, "R3 wrong key", d, 32'h10);
    bus_wr(5'h18, 32'h5AA5);
    bus_wr(5'h1C, 32'h0);
    bus_wr(5'h10, 32'h40);
    bus_rd(5'h10, d); chk(d == 32'h10, "R3 key used by other write", d, 32'h10);
    set_ctrl(32'h0);
  endtask

  task automatic t_timing();
    int ti, tr, nr;
    logic [31:0] d;
    set_ctrl(32'h0000_000B);
    time_events(200, ti, tr, nr);
    chk(ti == 65, "R5 irq at 2^6+1", ti, 65);
    chk(tr == 192, "R6 reset at 64+128", tr, 192);
    chk(nr == 1, "R6 reset one cycle", nr, 1);
    set_ctrl(32'h0);
    bus_rd(5'h1C, d); chk(d == 32'h2, "R7 sticky flag", d, 2);
    chk(irq == 1'b1, "R7 irq level held", irq, 1);
    bus_wr(5'h1C, 32'h2);
    chk(irq == 1'b0, "R7 W1C clears irq", irq, 0);
    set_ctrl(32'h0000_011B);
    time_events(600, ti, tr, nr);
    chk(ti == 257, "R5 code 1 irq at 2^8+1", ti, 257);
    chk(tr == 512, "R6 code 1 reset at 256+256", tr, 512);
    cleanup();
  endtask

  task automatic t_noarm();
    int ti, tr, nr;
    set_ctrl(32'h0000_0003);
    time_events(300, ti, tr, nr);
    chk(ti == 65, "R8 irq still raised", ti, 65);
    chk(nr == 0, "R8 no reset without arm", nr, 0);
    cleanup();
  endtask

  task automatic t_kick();
    int ti, tr, nr;
    set_ctrl(32'h0000_000B);
    idle(40);
    bus_wr(5'h18, 32'h5AA5);
    bus_wr(5'h14, 32'hCAFE);
    time_events(100, ti, tr, nr);
    chk(ti == 65, "R4 restart reloads window", ti, 65);
    cleanup();
    set_ctrl(32'h0000_000B);
    bus_wr(5'h18, 32'h5AA5);
    bus_wr(5'h14, 32'h1234);
    time_events(100, ti, tr, nr);
    chk(ti == 59, "R4 bad restart value ignored", ti, 59);
    cleanup();
    set_ctrl(32'h0000_000B);
    bus_wr(5'h14, 32'hCAFE);
    time_events(100, ti, tr, nr);
    chk(ti == 62, "R3 restart without key ignored", ti, 62);
    cleanup();
  endtask

  task automatic t_disable();
    int ti, tr, nr;
    set_ctrl(32'h0000_000B);
    idle(40);
    set_ctrl(32'h0);
    time_events(100, ti, tr, nr);
    chk(ti == -1, "R10 stopped counter", ti, -1);
    set_ctrl(32'h0000_000B);
    time_events(100, ti, tr, nr);
    chk(ti == 65, "R10 full window after re-enable", ti, 65);
    cleanup();
  endtask

  task automatic t_tick();
    set_ctrl(32'h0000_0009);
    idle(200);
    chk(irq == 1'b0, "R9 no ticks no progress", irq, 0);
    for (int i = 0; i < 63; i++) begin
      @(negedge clk); tick_in = 1'b1;
      @(negedge clk); tick_in = 1'b0;
    end
    idle(3);
    chk(irq == 1'b0, "R9 63 ticks short of window", irq, 0);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
    @(negedge clk);
    chk(irq == 1'b1, "R9 64th tick expires window", irq, 1);
    cleanup();
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    t_reset();
    t_fields();
    t_lock();
    t_timing();
    t_noarm();
    t_kick();
    t_disable();
    t_tick();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule